// File: doc/BRIEF.md
# I2C Master SCL/SDA Timing Generator

This block sets the bus timing for an I2C master. Counts are in peripheral clock cycles. While the controller is enabled it produces a free-running SCL waveform as a series of low and high phases. It tells the bit-level engine when each SCL edge happens through one-cycle ticks. It also issues a one-cycle SDA update strobe a programmable hold delay after each falling edge of SCL.

Three high/low count pairs are held, one for standard mode, one for fast mode and one for high-speed mode. A 2-bit speed field picks the pair in use. Each phase length is the selected count plus a fixed hardware offset, and a count below its minimum is raised to that minimum. Counts, hold value and speed field are captured only while the controller is disabled. A change made while running waits until the next disable.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, and after reset, `scl_out` is 1 and `rise_tick`, `fall_tick` and `sda_update` are 0.
- R2: Each SCL high phase (`scl_out`=1 while enabled) lasts max(high count, 6) + 8 clock cycles.
- R3: Each SCL low phase lasts max(low count, 8) + 1 clock cycles.
- R4: A low count below 8 behaves exactly as 8, and a high count below 6 behaves exactly as 6.
- R5: Speed field value 1 selects the standard pair, 2 the fast pair and 3 the high-speed pair. The reserved value 0 selects the standard pair.
- R6: `sda_update` pulses for one cycle exactly hold + 2 cycles after the cycle in which `fall_tick` is high.
- R7: If SCL would rise no later than the hold delay ends (hold + 2 >= low phase length), that strobe is dropped. `sda_update` is never high during a high phase.
- R8: Count, hold and speed inputs are captured only on clock edges where `enable` is low. Changes made while enabled do not alter the running waveform.
- R9: `fall_tick` is high for exactly the first cycle of every low phase and `rise_tick` for exactly the first cycle of every high phase. The first low phase begins in the cycle after the first edge at which `enable` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller enable; high runs SCL, low idles and allows configuration capture |
| speed | input | 2 | Speed field: 1 standard, 2 fast, 3 high speed, 0 treated as standard |
| std_hi_cnt | input | CNT_W | Standard mode high count |
| std_lo_cnt | input | CNT_W | Standard mode low count |
| fast_hi_cnt | input | CNT_W | Fast mode high count |
| fast_lo_cnt | input | CNT_W | Fast mode low count |
| hs_hi_cnt | input | CNT_W | High-speed mode high count |
| hs_lo_cnt | input | CNT_W | High-speed mode low count |
| hold_cnt | input | HOLD_W | SDA hold count; delay is hold_cnt + 2 cycles |
| scl_out | output | 1 | SCL level: 1 high phase or idle, 0 low phase |
| rise_tick | output | 1 | One-cycle marker of the first high cycle |
| fall_tick | output | 1 | One-cycle marker of the first low cycle |
| sda_update | output | 1 | One-cycle strobe that allows SDA to change |

## Verification
The first `fall_tick` is due one cycle after the edge that samples `enable` high. From then on, every low phase and every high phase is measured by counting cycles between ticks, and each count is compared with the clamped count plus its offset. The `sda_update` strobe is located by its cycle index from the falling tick and must land at hold + 2, or not at all when that index reaches the rising tick. All outputs are sampled on the falling clock edge, and inputs change there too, so each check reads the value one register stage has settled on. A sweep over speed values, small and clamped counts and boundary hold values gives near-exhaustive coverage of the selection and clamp arithmetic.

// File: rtl/scl_timing_pkg.sv
// Package: shared constants and types for the SCL/SDA timing generator.
// Assumes counts are unsigned peripheral clock cycle numbers.
package scl_timing_pkg;
    localparam int HI_MIN   = 6;  // smallest effective high count
    localparam int LO_MIN   = 8;  // smallest effective low count
    localparam int HI_OFS   = 8;  // fixed cycles added to a high phase
    localparam int LO_OFS   = 1;  // fixed cycles added to a low phase
    localparam int HOLD_OFS = 2;  // fixed cycles added to the SDA hold delay
    localparam int NPAIR    = 3;  // count pairs: standard, fast, high speed

    typedef enum logic [1:0] {
        SPD_RSVD = 2'd0,
        SPD_STD  = 2'd1,
        SPD_FAST = 2'd2,
        SPD_HIGH = 2'd3
    } speed_e;
endpackage

// File: rtl/scl_cfg_latch.sv
// Module: scl_cfg_latch
// Captures the count pairs, hold count and speed field while the controller
// is disabled. It then picks the active pair, applies the minimum clamps and
// adds the phase offsets. Assumes pair index 0 standard, 1 fast, 2 high speed.
module scl_cfg_latch
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16,
    parameter int LEN_W  = CNT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [1:0]                  speed_i,
    input  logic [NPAIR-1:0][CNT_W-1:0] hi_cnt_i,
    input  logic [NPAIR-1:0][CNT_W-1:0] lo_cnt_i,
    input  logic [HOLD_W-1:0]           hold_i,
    output logic [LEN_W-1:0]            hi_len_o,
    output logic [LEN_W-1:0]            lo_len_o,
    output logic [HOLD_W-1:0]           hold_o
);
    logic [NPAIR-1:0][CNT_W-1:0] hi_q;
    logic [NPAIR-1:0][CNT_W-1:0] lo_q;
    logic [1:0]                  speed_q;
    logic [HOLD_W-1:0]           hold_q;
    logic [1:0]                  sel;
    logic [CNT_W-1:0]            hi_eff;
    logic [CNT_W-1:0]            lo_eff;

    // One capture register pair per speed mode.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        // Capture this pair only while the controller is disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[p] <= '0;
                lo_q[p] <= '0;
            end else if (!enable) begin
                hi_q[p] <= hi_cnt_i[p];
                lo_q[p] <= lo_cnt_i[p];
            end
        end
    end

    // Capture speed field and hold count while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= SPD_STD;
            hold_q  <= '0;
        end else if (!enable) begin
            speed_q <= speed_i;
            hold_q  <= hold_i;
        end
    end

    // Map the speed field onto a pair index; the reserved code falls to standard.
    always_comb begin
        unique case (speed_e'(speed_q))
            SPD_FAST: sel = 2'd1;
            SPD_HIGH: sel = 2'd2;
            default:  sel = 2'd0;
        endcase
    end

    // Clamp the selected counts and add the fixed phase offsets.
    always_comb begin
        hi_eff   = (hi_q[sel] < CNT_W'(HI_MIN)) ? CNT_W'(HI_MIN) : hi_q[sel];
        lo_eff   = (lo_q[sel] < CNT_W'(LO_MIN)) ? CNT_W'(LO_MIN) : lo_q[sel];
        hi_len_o = LEN_W'(hi_eff) + LEN_W'(HI_OFS);
        lo_len_o = LEN_W'(lo_eff) + LEN_W'(LO_OFS);
        hold_o   = hold_q;
    end

    // R8: configuration seen by the generator holds still while enabled.
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rst_n) |=> ($stable(hi_len_o) && $stable(lo_len_o) && $stable(hold_o)));

    // R4: phase lengths never fall below clamp plus offset.
    a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_len_o >= LEN_W'(HI_MIN + HI_OFS)) && (lo_len_o >= LEN_W'(LO_MIN + LO_OFS)));
endmodule

// File: rtl/scl_phase_gen.sv
// Module: scl_phase_gen
// Runs the SCL phase counter: a low phase of lo_len cycles, then a high phase
// of hi_len cycles, repeated while enabled. Registered ticks mark the first
// cycle of each phase. Next-edge events go out combinationally for the hold
// timer. Assumes the lengths stay stable while enabled.
module scl_phase_gen #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] hi_len_i,
    input  logic [LEN_W-1:0] lo_len_i,
    output logic             scl_o,
    output logic             rise_tick_o,
    output logic             fall_tick_o,
    output logic             rise_evt_o,
    output logic             fall_evt_o
);
    logic             running;
    logic             phase_hi;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             at_end;

    // Decide which phase boundary, if any, the coming edge crosses.
    always_comb begin
        cur_len    = phase_hi ? hi_len_i : lo_len_i;
        at_end     = (cnt == cur_len - LEN_W'(1));
        rise_evt_o = enable && running && !phase_hi && at_end;
        fall_evt_o = enable && (!running || (phase_hi && at_end));
    end

    // Advance the phase counter and register the edge ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running     <= 1'b0;
            phase_hi    <= 1'b1;
            cnt         <= '0;
            rise_tick_o <= 1'b0;
            fall_tick_o <= 1'b0;
        end else begin
            running     <= 1'b1;
            rise_tick_o <= rise_evt_o;
            fall_tick_o <= fall_evt_o;
            if (fall_evt_o) begin
                phase_hi <= 1'b0;
                cnt      <= '0;
            end else if (rise_evt_o) begin
                phase_hi <= 1'b1;
                cnt      <= '0;
            end else begin
                cnt <= cnt + LEN_W'(1);
            end
        end
    end

    assign scl_o = phase_hi;

    // R9: the two ticks never coincide.
    a_r9_tick_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick_o, fall_tick_o}));
    // R9: a rising tick sits in a high cycle and a falling tick in a low one.
    a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick_o |-> scl_o);
    a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick_o |-> !scl_o);
    // R3: the phase counter stays inside the current phase length.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < cur_len));
    // R1: disabling idles SCL high with no ticks.
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && rst_n) |=> (scl_o && !rise_tick_o && !fall_tick_o));
endmodule

// File: rtl/sda_hold_timer.sv
// Module: sda_hold_timer
// Counts hold + 2 cycles from each SCL falling tick and then strobes
// sda_update for one cycle. A rising edge or a disable drops a pending
// strobe. Assumes fall/rise events mark the edge that sets the matching tick.
module sda_hold_timer
    import scl_timing_pkg::*;
#(
    parameter int HOLD_W = 16,
    parameter int HC_W   = HOLD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fall_evt_i,
    input  logic              rise_evt_i,
    input  logic              scl_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              sda_update_o
);
    logic            busy;
    logic [HC_W-1:0] hcnt;
    logic [HC_W-1:0] target;

    // Count value reached one edge before the strobe cycle.
    assign target = HC_W'(hold_i) + HC_W'(HOLD_OFS - 1);

    // Load on a fall, cancel on a rise, strobe when the hold delay expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy         <= 1'b0;
            hcnt         <= '0;
            sda_update_o <= 1'b0;
        end else begin
            sda_update_o <= 1'b0;
            if (fall_evt_i) begin
                busy <= 1'b1;
                hcnt <= '0;
            end else if (rise_evt_i) begin
                busy <= 1'b0;
            end else if (busy) begin
                if (hcnt == target) begin
                    sda_update_o <= 1'b1;
                    busy         <= 1'b0;
                end else begin
                    hcnt <= hcnt + HC_W'(1);
                end
            end
        end
    end

    // R7: the strobe only ever appears while SCL is low.
    a_r7_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        sda_update_o |-> !scl_i);
    // R6: the strobe lasts a single cycle.
    a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_update_o |=> !sda_update_o);
endmodule

// File: rtl/scl_timing_gen.sv
// Module: scl_timing_gen (top)
// I2C master SCL/SDA timing generator: it captures configuration while
// disabled, runs the SCL phases while enabled and strobes SDA changes after
// the hold delay. Assumes a single clock domain and synchronous reset.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        speed,
    input  logic [CNT_W-1:0]  std_hi_cnt,
    input  logic [CNT_W-1:0]  std_lo_cnt,
    input  logic [CNT_W-1:0]  fast_hi_cnt,
    input  logic [CNT_W-1:0]  fast_lo_cnt,
    input  logic [CNT_W-1:0]  hs_hi_cnt,
    input  logic [CNT_W-1:0]  hs_lo_cnt,
    input  logic [HOLD_W-1:0] hold_cnt,
    output logic              scl_out,
    output logic              rise_tick,
    output logic              fall_tick,
    output logic              sda_update
);
    localparam int LEN_W = CNT_W + 1;

    logic [NPAIR-1:0][CNT_W-1:0] hi_bus;
    logic [NPAIR-1:0][CNT_W-1:0] lo_bus;
    logic [LEN_W-1:0]            hi_len;
    logic [LEN_W-1:0]            lo_len;
    logic [HOLD_W-1:0]           hold_act;
    logic                        rise_evt;
    logic                        fall_evt;

    assign hi_bus = {hs_hi_cnt, fast_hi_cnt, std_hi_cnt};
    assign lo_bus = {hs_lo_cnt, fast_lo_cnt, std_lo_cnt};

    scl_cfg_latch #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .speed_i  (speed),
        .hi_cnt_i (hi_bus),
        .lo_cnt_i (lo_bus),
        .hold_i   (hold_cnt),
        .hi_len_o (hi_len),
        .lo_len_o (lo_len),
        .hold_o   (hold_act)
    );

    scl_phase_gen #(.LEN_W(LEN_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .hi_len_i    (hi_len),
        .lo_len_i    (lo_len),
        .scl_o       (scl_out),
        .rise_tick_o (rise_tick),
        .fall_tick_o (fall_tick),
        .rise_evt_o  (rise_evt),
        .fall_evt_o  (fall_evt)
    );

    sda_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .fall_evt_i   (fall_evt),
        .rise_evt_i   (rise_evt),
        .scl_i        (scl_out),
        .hold_i       (hold_act),
        .sda_update_o (sda_update)
    );
endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  speed = 2'd1;
    logic [15:0] std_hi = '0, std_lo = '0, fast_hi = '0, fast_lo = '0;
    logic [15:0] hs_hi = '0, hs_lo = '0, hold = '0;
    logic        scl_out, rise_tick, fall_tick, sda_update;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scl_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed(speed),
        .std_hi_cnt(std_hi), .std_lo_cnt(std_lo),
        .fast_hi_cnt(fast_hi), .fast_lo_cnt(fast_lo),
        .hs_hi_cnt(hs_hi), .hs_lo_cnt(hs_lo), .hold_cnt(hold),
        .scl_out(scl_out), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .sda_update(sda_update)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lo_val(input int k);
        case (k) 0: return 0; 1: return 7; 2: return 8; 3: return 9; default: return 13; endcase
    endfunction
    function automatic int hi_val(input int k);
        case (k) 0: return 0; 1: return 5; 2: return 6; 3: return 7; default: return 11; endcase
    endfunction
    function automatic int hold_val(input int k);
        case (k) 0: return 0; 1: return 6; 2: return 7; default: return 40; endcase
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Check idle outputs (R1).
    task automatic check_idle(input string tag);
        check(scl_out === 1'b1, {"R1 scl idle ", tag}, int'(scl_out), 1);
        check({rise_tick, fall_tick, sda_update} === 3'b000, {"R1 no strobes ", tag},
              int'({rise_tick, fall_tick, sda_update}), 0);
    endtask

    // Enable, measure one low and one high phase, then disable.
    task automatic run(input int exp_lo, input int exp_hi, input int hv,
                       input bit perturb, input string tag);
        int low_n, high_n, upd_pos, upd_high, exp_pos, guard;
        @(negedge clk) enable = 1'b1;
        @(negedge clk);
        check(fall_tick === 1'b1 && scl_out === 1'b0, {"R9 first fall tick ", tag},
              int'({fall_tick, scl_out}), 2);
        if (perturb) begin
            speed = 2'd3; std_hi = 16'd30; std_lo = 16'd30; hs_hi = 16'd25; hs_lo = 16'd25;
            fast_hi = 16'd20; fast_lo = 16'd20; hold = 16'd1;
        end
        low_n = 1; upd_pos = -1; upd_high = 0; guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (rise_tick === 1'b1 || guard > 1000) break;
            low_n++;
            if (sda_update === 1'b1) upd_pos = low_n - 1;
        end
        check(scl_out === 1'b1, {"R9 rise tick in high ", tag}, int'(scl_out), 1);
        if (perturb) check(low_n == exp_lo, {"R8 low len frozen ", tag}, low_n, exp_lo);
        else         check(low_n == exp_lo, {"R3 low len ", tag}, low_n, exp_lo);
        high_n = 1; guard = 0;
        if (sda_update === 1'b1) upd_high++;
        forever begin
            @(negedge clk);
            guard++;
            if (fall_tick === 1'b1 || guard > 1000) break;
            high_n++;
            if (sda_update === 1'b1) upd_high++;
        end
        if (perturb) check(high_n == exp_hi, {"R8 high len frozen ", tag}, high_n, exp_hi);
        else         check(high_n == exp_hi, {"R2 high len ", tag}, high_n, exp_hi);
        check(upd_high == 0, {"R7 no strobe in high ", tag}, upd_high, 0);
        exp_pos = (hv + 2 < exp_lo) ? hv + 2 : -1;
        if (exp_pos < 0) check(upd_pos == -1, {"R7 strobe dropped ", tag}, upd_pos, -1);
        else             check(upd_pos == exp_pos, {"R6 strobe offset ", tag}, upd_pos, exp_pos);
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        check_idle(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        // Sweep of speed codes, clamped/unclamped counts and hold boundaries.
        for (int sp = 0; sp < 4; sp++) begin
            for (int k = 0; k < 5; k++) begin
                for (int h = 0; h < 4; h++) begin
                    int lo, hi, elo, ehi;
                    string tag;
                    lo = lo_val(k); hi = hi_val(k);
                    speed = 2'(sp); hold = 16'(hold_val(h));
                    std_lo = 16'(lo);      std_hi = 16'(hi);
                    fast_lo = 16'(lo + 3); fast_hi = 16'(hi + 2);
                    hs_lo = 16'(lo + 6);   hs_hi = 16'(hi + 4);
                    // R5: pair chosen by speed code, 0 behaves as standard.
                    case (sp)
                        2: begin lo = lo + 3; hi = hi + 2; end
                        3: begin lo = lo + 6; hi = hi + 4; end
                        default: ;
                    endcase
                    // R4: clamps to 8 (low) and 6 (high).
                    elo = imax(lo, 8) + 1;
                    ehi = imax(hi, 6) + 8;
                    tag = $sformatf("R5 R4 sp%0d lo%0d hi%0d hold%0d", sp, lo, hi, hold_val(h));
                    @(negedge clk);
                    run(elo, ehi, hold_val(h), 1'b0, tag);
                end
            end
        end

        // R8: inputs changed while running are ignored until the next disable.
        speed = 2'd2; fast_lo = 16'd10; fast_hi = 16'd9; hold = 16'd3;
        @(negedge clk);
        run(11, 17, 3, 1'b1, "R8 perturb");
        // New values (captured while disabled) now apply: speed 3, hs 25/25, hold 1.
        @(negedge clk);
        run(26, 33, 1, 1'b0, "R8 recapture");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule